// File: doc/BRIEF.md
# Exception Priority and Vector Selector

This block looks at every exception and interrupt request raised in one cycle and decides which single event the processor services. It ranks requests first by level (resets, then general exceptions, then interrupts) and then by a fixed order inside the level. It produces the event code, the vector offset and one of four actions: take the event, force a reset, ignore the event, or keep it pending. It also holds the exception event register, which records the code of every taken exception or reset, and a separate interrupt event register, which records the source code of an accepted interrupt.

The status-register block bit changes how each general event is handled. Faults and traps that arrive while it is set escalate to a reset. Break events are dropped. A DMA address error or an interrupt waits until the bit clears. A DMA address error is retained inside the block until it is serviced. Any other request that loses to a higher-ranked event in the same cycle is dropped. Requests are expected to come from registers. Selection is combinational and every result is registered, so results appear one cycle after the requests.

Top module: `excsel_top`

## Requirements
- R1: Reset requests on `rstReq` outrank all other requests: bit 0 (power-on, code 0xA00) wins over bit 1 (debug, code 0x000), which wins over bit 2 (manual, code 0x020). The result is action 1 (reset), offset 0, and the code is written into the exception event register.
- R2: General requests on `genReq` are ranked by bit index, lowest index first: 0 break before execution (0x1E0), 1 instruction-fetch address error (0x0E0), 2 illegal instruction (0x180), 3 illegal slot instruction (0x1A0), 4 data-access address error, 5 trap (0x160), 6 break after execution (0x1E0), 7 DMA address error (0x5C0).
- R3: A data-access address error reports code 0x0E0 when `dataWrite` is 0 and code 0x100 when it is 1.
- R4: With the block bit clear, a winning general exception gives action 0 (take), a `takeStrobe` pulse, offset 0x100, and a write of its code to the exception event register.
- R5: With the block bit set, a winning request on bits 1 to 5 gives action 1 (reset), code 0x020 and offset 0, and writes 0x020 to the exception event register.
- R6: With the block bit set, a winning break request (bit 0 or 6) gives action 2 (ignore), reports code 0x1E0 and offset 0x100, and leaves the exception event register unchanged. A lower-ranked request in the same cycle that is not retained is dropped.
- R7: A DMA address error that is not serviced is retained. While the block bit is set it gives action 3 (hold) with code 0x5C0 and offset 0x100, every cycle. Once the bit clears it is taken without a new request and then released.
- R8: An interrupt is accepted only when no general exception, including a retained one, is present. When accepted it gives action 0, code `intCode`, offset 0x600, and it copies `intCode` to the interrupt event register. The exception event register is unchanged.
- R9: An interrupt that wins while the block bit is set gives action 3 (hold) with code `intCode` and offset 0x600, and neither event register changes.
- R10: `rstN` low sets the exception event register to 0xA00, the interrupt event register to 0, and clears the retained DMA request. A power-on reset request also clears the retained DMA request.
- R11: All results are registered and appear one cycle after the requests. The action is encoded 0 take, 1 reset, 2 ignore, 3 hold. A cycle with no request and nothing retained gives `evtValid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rstReq | input | 3 | Reset requests: power-on, debug, manual |
| genReq | input | 8 | General exception requests, bit index = order |
| dataWrite | input | 1 | Data-access address error was a write |
| blockBit | input | 1 | Status-register block bit |
| intPending | input | 1 | Interrupt controller has a request |
| intCode | input | 12 | Source code of the pending interrupt |
| evtValid | output | 1 | A decision was made last cycle |
| evtAction | output | 2 | Action of that decision |
| takeStrobe | output | 1 | Decision was a take |
| evtCode | output | 12 | Code of the selected event |
| vecOffset | output | 32 | Vector offset of the selected event |
| expEvtWe | output | 1 | Exception event register was written |
| expEvt | output | 12 | Exception event register |
| intEvt | output | 12 | Interrupt event register |

## Verification
Every decision output and both event registers change at the clock edge that follows the cycle in which the requests were applied. A retained DMA error shows up again on each later edge until it is serviced. The driver sets the inputs just after a falling edge and queues the values it expects after the next rising edge. The monitor samples a quarter period after that rising edge and pops one entry, so each result is compared exactly one cycle after its stimulus. Idle cycles are queued as well, which lets the monitor see dropped and retained requests at the ports.

// File: rtl/excsel_pkg.sv
`timescale 1ns/1ps
package excsel_pkg;
  typedef enum logic [1:0] {
    ACT_TAKE   = 2'd0,
    ACT_RESET  = 2'd1,
    ACT_IGNORE = 2'd2,
    ACT_HOLD   = 2'd3
  } act_e;

  typedef enum logic [3:0] {
    SRC_NONE, SRC_POR, SRC_DBG, SRC_MAN, SRC_ESC,
    SRC_BRK, SRC_IADDR, SRC_ILLG, SRC_ILLS, SRC_DADDR,
    SRC_TRAP, SRC_DMA, SRC_INT
  } src_e;

  typedef struct packed {
    logic fire;
    act_e act;
    src_e src;
    logic wrExp;
    logic wrInt;
  } strobe_t;

  localparam int RST_LINES = 3;
  localparam int GEN_LINES = 8;
  localparam int GEN_IDX_W = $clog2(GEN_LINES);
  // bit positions whose rank is behaviour
  localparam int POS_POR = 0;
  localparam int POS_DBG = 1;
  localparam int POS_MAN = 2;
  localparam int POS_BRK_PRE  = 0;
  localparam int POS_BRK_POST = 6;
  localparam int POS_DMA      = 7;

  localparam logic [11:0] CODE_POR   = 12'hA00;
  localparam logic [11:0] CODE_DBG   = 12'h000;
  localparam logic [11:0] CODE_MAN   = 12'h020;
  localparam logic [11:0] CODE_BRK   = 12'h1E0;
  localparam logic [11:0] CODE_ADDR_RD = 12'h0E0;
  localparam logic [11:0] CODE_ADDR_WR = 12'h100;
  localparam logic [11:0] CODE_ILLG  = 12'h180;
  localparam logic [11:0] CODE_ILLS  = 12'h1A0;
  localparam logic [11:0] CODE_TRAP  = 12'h160;
  localparam logic [11:0] CODE_DMA   = 12'h5C0;
endpackage

// File: rtl/excsel_ctrl.sv
`timescale 1ns/1ps
module excsel_ctrl
  import excsel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [RST_LINES-1:0] rstReq,
  input  logic [GEN_LINES-1:0] genReq,
  input  logic                 blockBit,
  input  logic                 intPending,
  output strobe_t              strobe
);
  logic                 dmaKept;
  logic [GEN_LINES-1:0] genEff;
  logic [GEN_LINES-1:0] genWin;
  logic [GEN_LINES:0]   genSeen;
  logic [GEN_IDX_W-1:0] winIdx;
  logic                 dmaTaken;
  logic                 porHit;

  // retained DMA error joins the live requests at its own rank
  always_comb begin
    genEff = genReq;
    genEff[POS_DMA] = genReq[POS_DMA] | dmaKept;
  end

  // first-set chain: a request wins when nothing lower-indexed is present
  assign genSeen[0] = 1'b0;
  generate
    for (genvar g = 0; g < GEN_LINES; g++) begin : g_rank
      assign genWin[g]    = genEff[g] & ~genSeen[g];
      assign genSeen[g+1] = genSeen[g] | genEff[g];
    end
  endgenerate

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < GEN_LINES; i++) begin
      if (genWin[i]) winIdx = GEN_IDX_W'(i);
    end
  end

  function automatic src_e genSrc(input logic [GEN_IDX_W-1:0] idx);
    case (idx)
      GEN_IDX_W'(1): genSrc = SRC_IADDR;
      GEN_IDX_W'(2): genSrc = SRC_ILLG;
      GEN_IDX_W'(3): genSrc = SRC_ILLS;
      GEN_IDX_W'(4): genSrc = SRC_DADDR;
      GEN_IDX_W'(5): genSrc = SRC_TRAP;
      GEN_IDX_W'(7): genSrc = SRC_DMA;
      default:       genSrc = SRC_BRK;
    endcase
  endfunction

  always_comb begin
    strobe   = '{fire: 1'b0, act: ACT_TAKE, src: SRC_NONE, wrExp: 1'b0, wrInt: 1'b0};
    dmaTaken = 1'b0;
    porHit   = 1'b0;
    if (|rstReq) begin
      strobe.fire  = 1'b1;
      strobe.act   = ACT_RESET;
      strobe.wrExp = 1'b1;
      if (rstReq[POS_POR]) begin
        strobe.src = SRC_POR;
        porHit     = 1'b1;
      end else if (rstReq[POS_DBG]) begin
        strobe.src = SRC_DBG;
      end else begin
        strobe.src = SRC_MAN;
      end
    end else if (|genEff) begin
      strobe.fire = 1'b1;
      strobe.src  = genSrc(winIdx);
      if (winIdx == GEN_IDX_W'(POS_BRK_PRE) || winIdx == GEN_IDX_W'(POS_BRK_POST)) begin
        strobe.act   = blockBit ? ACT_IGNORE : ACT_TAKE;
        strobe.wrExp = ~blockBit;
      end else if (winIdx == GEN_IDX_W'(POS_DMA)) begin
        strobe.act   = blockBit ? ACT_HOLD : ACT_TAKE;
        strobe.wrExp = ~blockBit;
        dmaTaken     = ~blockBit;
      end else if (blockBit) begin
        strobe.act   = ACT_RESET;
        strobe.src   = SRC_ESC;
        strobe.wrExp = 1'b1;
      end else begin
        strobe.wrExp = 1'b1;
      end
    end else if (intPending) begin
      strobe.fire  = 1'b1;
      strobe.src   = SRC_INT;
      strobe.act   = blockBit ? ACT_HOLD : ACT_TAKE;
      strobe.wrInt = ~blockBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaKept <= 1'b0;
    end else if (porHit || dmaTaken) begin
      dmaKept <= 1'b0;
    end else begin
      dmaKept <= genEff[POS_DMA];
    end
  end
endmodule

// File: rtl/excsel_dp.sv
`timescale 1ns/1ps
module excsel_dp
  import excsel_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int OFS_W   = 32,
  parameter int GEN_OFS = 'h100,
  parameter int INT_OFS = 'h600
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              dataWrite,
  input  logic [CODE_W-1:0] intCode,
  output logic              evtValid,
  output logic [1:0]        evtAction,
  output logic              takeStrobe,
  output logic [CODE_W-1:0] evtCode,
  output logic [OFS_W-1:0]  vecOffset,
  output logic              expEvtWe,
  output logic [CODE_W-1:0] expEvt,
  output logic [CODE_W-1:0] intEvt
);
  logic [CODE_W-1:0] codeSel;
  logic [OFS_W-1:0]  ofsSel;

  always_comb begin
    case (strobe.src)
      SRC_POR:   codeSel = CODE_W'(CODE_POR);
      SRC_DBG:   codeSel = CODE_W'(CODE_DBG);
      SRC_MAN,
      SRC_ESC:   codeSel = CODE_W'(CODE_MAN);
      SRC_BRK:   codeSel = CODE_W'(CODE_BRK);
      SRC_IADDR: codeSel = CODE_W'(CODE_ADDR_RD);
      SRC_ILLG:  codeSel = CODE_W'(CODE_ILLG);
      SRC_ILLS:  codeSel = CODE_W'(CODE_ILLS);
      SRC_DADDR: codeSel = dataWrite ? CODE_W'(CODE_ADDR_WR) : CODE_W'(CODE_ADDR_RD);
      SRC_TRAP:  codeSel = CODE_W'(CODE_TRAP);
      SRC_DMA:   codeSel = CODE_W'(CODE_DMA);
      SRC_INT:   codeSel = intCode;
      default:   codeSel = '0;
    endcase
    case (strobe.src)
      SRC_NONE, SRC_POR, SRC_DBG, SRC_MAN, SRC_ESC: ofsSel = '0;
      SRC_INT: ofsSel = OFS_W'(INT_OFS);
      default: ofsSel = OFS_W'(GEN_OFS);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid   <= 1'b0;
      evtAction  <= 2'd0;
      takeStrobe <= 1'b0;
      evtCode    <= '0;
      vecOffset  <= '0;
      expEvtWe   <= 1'b0;
      expEvt     <= CODE_W'(CODE_POR);
      intEvt     <= '0;
    end else begin
      evtValid   <= strobe.fire;
      evtAction  <= strobe.act;
      takeStrobe <= strobe.fire && (strobe.act == ACT_TAKE);
      evtCode    <= codeSel;
      vecOffset  <= ofsSel;
      expEvtWe   <= strobe.fire && strobe.wrExp;
      if (strobe.fire && strobe.wrExp) expEvt <= codeSel;
      if (strobe.fire && strobe.wrInt) intEvt <= intCode;
    end
  end
endmodule

// File: rtl/excsel_top.sv
`timescale 1ns/1ps
module excsel_top
  import excsel_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int OFS_W   = 32,
  parameter int GEN_OFS = 'h100,
  parameter int INT_OFS = 'h600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        rstReq,
  input  logic [7:0]        genReq,
  input  logic              dataWrite,
  input  logic              blockBit,
  input  logic              intPending,
  input  logic [CODE_W-1:0] intCode,
  output logic              evtValid,
  output logic [1:0]        evtAction,
  output logic              takeStrobe,
  output logic [CODE_W-1:0] evtCode,
  output logic [OFS_W-1:0]  vecOffset,
  output logic              expEvtWe,
  output logic [CODE_W-1:0] expEvt,
  output logic [CODE_W-1:0] intEvt
);
  strobe_t strobe;

  excsel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rstReq(rstReq), .genReq(genReq),
    .blockBit(blockBit), .intPending(intPending), .strobe(strobe)
  );

  excsel_dp #(.CODE_W(CODE_W), .OFS_W(OFS_W), .GEN_OFS(GEN_OFS), .INT_OFS(INT_OFS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataWrite(dataWrite), .intCode(intCode),
    .evtValid(evtValid), .evtAction(evtAction), .takeStrobe(takeStrobe),
    .evtCode(evtCode), .vecOffset(vecOffset), .expEvtWe(expEvtWe),
    .expEvt(expEvt), .intEvt(intEvt)
  );
endmodule

// File: rtl/excsel_chk.sv
`timescale 1ns/1ps
module excsel_chk #(
  parameter int CODE_W  = 12,
  parameter int OFS_W   = 32,
  parameter int INT_OFS = 'h600
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        rstReq,
  input logic [7:0]        genReq,
  input logic              blockBit,
  input logic              intPending,
  input logic              evtValid,
  input logic [1:0]        evtAction,
  input logic              takeStrobe,
  input logic [CODE_W-1:0] evtCode,
  input logic [OFS_W-1:0]  vecOffset,
  input logic              expEvtWe,
  input logic [CODE_W-1:0] expEvt
);
  assert_por_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    rstReq[0] |=> (evtAction == 2'd1) && (expEvt == CODE_W'('hA00)) && expEvtWe);

  assert_trap_escalate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (blockBit && genReq[5] && rstReq == 3'b0 && genReq[4:0] == 5'b0)
      |=> (evtAction == 2'd1) && (evtCode == CODE_W'('h020)) && (expEvt == CODE_W'('h020)));

  assert_ignore_keeps_reg_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtAction == 2'd2) |-> !expEvtWe && $stable(expEvt));

  assert_hold_keeps_reg_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtAction == 2'd3) |-> !expEvtWe && !takeStrobe && $stable(expEvt));

  assert_int_keeps_reg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (takeStrobe && vecOffset == OFS_W'(INT_OFS)) |-> !expEvtWe && $stable(expEvt));

  assert_int_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (blockBit && intPending && rstReq == 3'b0 && genReq == 8'b0) |=> !takeStrobe && !expEvtWe);

  assert_take_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> evtValid && evtAction == 2'd0);
endmodule

bind excsel_top excsel_chk #(.CODE_W(CODE_W), .OFS_W(OFS_W), .INT_OFS(INT_OFS)) u_chk (
  .clk(clk), .rstN(rstN), .rstReq(rstReq), .genReq(genReq), .blockBit(blockBit),
  .intPending(intPending), .evtValid(evtValid), .evtAction(evtAction),
  .takeStrobe(takeStrobe), .evtCode(evtCode), .vecOffset(vecOffset),
  .expEvtWe(expEvtWe), .expEvt(expEvt)
);

// File: tb/excsel_top_tb.sv
`timescale 1ns/1ps
module excsel_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  rstReq = '0;
  logic [7:0]  genReq = '0;
  logic        dataWrite = 1'b0;
  logic        blockBit = 1'b0;
  logic        intPending = 1'b0;
  logic [11:0] intCode = '0;
  logic        evtValid, takeStrobe, expEvtWe;
  logic [1:0]  evtAction;
  logic [11:0] evtCode, expEvt, intEvt;
  logic [31:0] vecOffset;

  typedef struct packed {
    logic        valid;
    logic [1:0]  act;
    logic        take;
    logic [11:0] code;
    logic [31:0] ofs;
    logic        we;
    logic [11:0] ee;
    logic [11:0] ie;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;

  always #10 clk = ~clk;

  excsel_top u_dut (
    .clk(clk), .rstN(rstN), .rstReq(rstReq), .genReq(genReq), .dataWrite(dataWrite),
    .blockBit(blockBit), .intPending(intPending), .intCode(intCode),
    .evtValid(evtValid), .evtAction(evtAction), .takeStrobe(takeStrobe),
    .evtCode(evtCode), .vecOffset(vecOffset), .expEvtWe(expEvtWe),
    .expEvt(expEvt), .intEvt(intEvt)
  );

  function automatic exp_t mk(input logic v, input logic [1:0] a, input logic [11:0] c,
                              input logic [31:0] o, input logic w, input logic [11:0] e,
                              input logic [11:0] i);
    mk = '{valid: v, act: a, take: v && (a == 2'd0), code: c, ofs: o, we: w, ee: e, ie: i};
  endfunction

  task automatic drive(input logic [2:0] r, input logic [7:0] g, input logic dw,
                       input logic bl, input logic ip, input logic [11:0] ic,
                       input exp_t e, input string tag);
    @(negedge clk);
    rstReq = r; genReq = g; dataWrite = dw; blockBit = bl; intPending = ip; intCode = ic;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: results are due one rising edge after the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        exp_t  e;
        exp_t  a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = '{valid: evtValid, act: evtAction, take: takeStrobe, code: evtCode,
              ofs: vecOffset, we: expEvtWe, ee: expEvt, ie: intEvt};
        checks++;
        if (e.valid == 1'b0) begin
          if (a.valid !== 1'b0 || a.take !== 1'b0 || a.we !== 1'b0 || a.ee !== e.ee || a.ie !== e.ie) begin
            fails++;
            $display("FAIL %s: actual %h expected idle with ee=%h ie=%h", t, a, e.ee, e.ie);
          end
        end else if (a !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (evtValid !== 1'b0 || expEvt !== 12'hA00 || intEvt !== 12'h000) begin
      fails++;
      $display("FAIL R10 reset state: actual v=%b ee=%h ie=%h expected v=0 ee=a00 ie=000",
               evtValid, expEvt, intEvt);
    end
    rstN = 1'b1;
    // R11 idle gives no decision
    drive(3'b000, 8'h00, 0, 0, 0, 12'h0, mk(0, 0, 0, 0, 0, 12'hA00, 12'h0), "R11 idle");
    // R4 / R2 single trap
    drive(3'b000, 8'h20, 0, 0, 0, 12'h0, mk(1, 0, 12'h160, 32'h100, 1, 12'h160, 12'h0), "R4 trap take");
    drive(3'b000, 8'h24, 0, 0, 0, 12'h0, mk(1, 0, 12'h180, 32'h100, 1, 12'h180, 12'h0), "R2 illegal over trap");
    drive(3'b000, 8'h08, 0, 0, 0, 12'h0, mk(1, 0, 12'h1A0, 32'h100, 1, 12'h1A0, 12'h0), "R2 slot illegal");
    drive(3'b000, 8'h10, 0, 0, 0, 12'h0, mk(1, 0, 12'h0E0, 32'h100, 1, 12'h0E0, 12'h0), "R3 data read error");
    drive(3'b000, 8'h10, 1, 0, 0, 12'h0, mk(1, 0, 12'h100, 32'h100, 1, 12'h100, 12'h0), "R3 data write error");
    drive(3'b000, 8'h03, 0, 0, 0, 12'h0, mk(1, 0, 12'h1E0, 32'h100, 1, 12'h1E0, 12'h0), "R2 pre-break over fetch error");
    drive(3'b000, 8'h02, 0, 0, 0, 12'h0, mk(1, 0, 12'h0E0, 32'h100, 1, 12'h0E0, 12'h0), "R2 fetch error");
    drive(3'b000, 8'h40, 0, 0, 0, 12'h0, mk(1, 0, 12'h1E0, 32'h100, 1, 12'h1E0, 12'h0), "R4 post-break take");
    // R5 escalation
    drive(3'b000, 8'h20, 0, 1, 0, 12'h0, mk(1, 1, 12'h020, 32'h0, 1, 12'h020, 12'h0), "R5 trap escalates");
    drive(3'b000, 8'h04, 0, 1, 0, 12'h0, mk(1, 1, 12'h020, 32'h0, 1, 12'h020, 12'h0), "R5 illegal escalates");
    // R6 ignore and drop
    drive(3'b000, 8'h21, 0, 1, 0, 12'h0, mk(1, 2, 12'h1E0, 32'h100, 0, 12'h020, 12'h0), "R6 break ignored");
    drive(3'b000, 8'h00, 0, 0, 0, 12'h0, mk(0, 0, 0, 0, 0, 12'h020, 12'h0), "R6 trap dropped");
    // R7 retention under block bit
    drive(3'b000, 8'h80, 0, 1, 0, 12'h0, mk(1, 3, 12'h5C0, 32'h100, 0, 12'h020, 12'h0), "R7 dma hold");
    drive(3'b000, 8'h00, 0, 1, 0, 12'h0, mk(1, 3, 12'h5C0, 32'h100, 0, 12'h020, 12'h0), "R7 dma still held");
    drive(3'b000, 8'h00, 0, 0, 0, 12'h0, mk(1, 0, 12'h5C0, 32'h100, 1, 12'h5C0, 12'h0), "R7 dma taken later");
    drive(3'b000, 8'h00, 0, 0, 0, 12'h0, mk(0, 0, 0, 0, 0, 12'h5C0, 12'h0), "R7 dma released");
    // R7 retention when outranked
    drive(3'b000, 8'hA0, 0, 0, 0, 12'h0, mk(1, 0, 12'h160, 32'h100, 1, 12'h160, 12'h0), "R7 trap beats dma");
    drive(3'b000, 8'h00, 0, 0, 0, 12'h0, mk(1, 0, 12'h5C0, 32'h100, 1, 12'h5C0, 12'h0), "R7 retained dma taken");
    // R8 interrupts
    drive(3'b000, 8'h00, 0, 0, 1, 12'h3A0, mk(1, 0, 12'h3A0, 32'h600, 0, 12'h5C0, 12'h3A0), "R8 interrupt taken");
    drive(3'b000, 8'h04, 0, 0, 1, 12'h4C0, mk(1, 0, 12'h180, 32'h100, 1, 12'h180, 12'h3A0), "R8 exception blocks interrupt");
    drive(3'b000, 8'h80, 0, 1, 0, 12'h0, mk(1, 3, 12'h5C0, 32'h100, 0, 12'h180, 12'h3A0), "R7 dma hold again");
    drive(3'b000, 8'h00, 0, 0, 1, 12'h4C0, mk(1, 0, 12'h5C0, 32'h100, 1, 12'h5C0, 12'h3A0), "R8 retained dma blocks interrupt");
    // R9
    drive(3'b000, 8'h00, 0, 1, 1, 12'h4C0, mk(1, 3, 12'h4C0, 32'h600, 0, 12'h5C0, 12'h3A0), "R9 interrupt held");
    // R1 resets
    drive(3'b100, 8'h20, 0, 0, 1, 12'h4C0, mk(1, 1, 12'h020, 32'h0, 1, 12'h020, 12'h3A0), "R1 manual reset");
    drive(3'b110, 8'h00, 0, 0, 0, 12'h0, mk(1, 1, 12'h000, 32'h0, 1, 12'h000, 12'h3A0), "R1 debug over manual");
    drive(3'b011, 8'h01, 0, 1, 0, 12'h0, mk(1, 1, 12'hA00, 32'h0, 1, 12'hA00, 12'h3A0), "R1 power-on over debug");
    // R10 power-on clears retained dma
    drive(3'b000, 8'h80, 0, 1, 0, 12'h0, mk(1, 3, 12'h5C0, 32'h100, 0, 12'hA00, 12'h3A0), "R10 dma held before power-on");
    drive(3'b001, 8'h00, 0, 1, 0, 12'h0, mk(1, 1, 12'hA00, 32'h0, 1, 12'hA00, 12'h3A0), "R10 power-on");
    drive(3'b000, 8'h00, 0, 0, 0, 12'h0, mk(0, 0, 0, 0, 0, 12'hA00, 12'h3A0), "R10 dma cleared");
    drive(3'b000, 8'h00, 0, 0, 0, 12'h0, mk(0, 0, 0, 0, 0, 12'hA00, 12'h3A0), "R11 idle end");
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule